// File: doc/BRIEF.md
# Aligned Load/Store Address Unit

This unit turns one load or store operation into a sequence of 16-bit word accesses in a 16-bit byte-addressed space. It forms the effective address for the addressing mode: base register, base plus displacement, absolute immediate, post-increment, post-decrement, or stack push with pre-decrement. It also works out the updated base value, checks word alignment, and raises bus-error or illegal-operation exceptions. A double-word operation becomes two word accesses to consecutive addresses that use an even/odd register pair.

The register file and the memory sit outside the unit. The unit names the register whose value a store puts on the bus. For a load, it hands the returned word to the register file on a write port. When the operation finishes, it presents the base-register update and a one-cycle completion pulse. That pulse tells the fetch logic whether the program counter may advance. Memory uses a request/acknowledge protocol. A request stays up with a fixed address until it is acknowledged, and read data is valid in the acknowledge cycle.

Top module: `lsu_addr_unit`

## Requirements
- R1: The effective address is `base_val` for mode 0 (indirect, 3'd0), `base_val + disp` for mode 1 (3'd1), `disp` for mode 2 (absolute, 3'd2), and `base_val` for modes 3 (post-increment) and 4 (post-decrement). All address sums wrap modulo 2^16.
- R2: An effective address with bit 0 set ends the operation with `bus_err` and `done` high. No memory request is issued, no base update is made, and `pc_adv` stays low.
- R3: In post-increment the base is written back as base+2 for a word and base+4 for a double word. In post-decrement it is written back as base-2 and base-4. Stores always write the base back in these modes.
- R4: A word load in mode 3 or 4 writes no base update when `data_idx` equals `base_idx`.
- R5: A double-word load in mode 3 or 4 writes no base update when `base_idx` equals `data_idx` or `data_idx+1` (register index wraps modulo 16).
- R6: A double-word operation makes two accesses. The first is at the address with register `data_idx`, the second at address+2 with register `data_idx+1`. Each load access writes the returned word to that register in its acknowledge cycle.
- R7: Two cases raise `ill_err` with no access, no base update and `pc_adv` low: a store in mode 4 with `base_idx` 15, and a load in mode 5 (3'd5) or in modes 6 and 7. This check takes precedence over the alignment check.
- R8: In mode 5 (stack push, stores only), the address is base-2 for a word and base-4 for a double word. Alignment is checked on that decremented address. After the memory writes, the same address is written back to the base register.
- R9: `done` is a single-cycle pulse. It comes one cycle after the last acknowledge, or one cycle after the accepted start for an exception. `pc_adv` is high with `done` exactly when no exception is raised.
- R10: A request holds `mem_addr`, `mem_we` and `mem_reg_idx` stable until acknowledged. A `start` raised while `busy` is ignored.
- R11: After reset the unit is idle. `busy`, `mem_req`, `rf_we`, `wb_we` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation (accepted when idle) |
| is_store | input | 1 | 1 = store, 0 = load |
| is_double | input | 1 | 1 = 32-bit double word, 0 = 16-bit word |
| mode | input | 3 | Addressing mode code (see R1, R7, R8) |
| base_idx | input | 4 | Base register index |
| data_idx | input | 4 | Destination (load) or source (store) register index |
| base_val | input | 16 | Current base register value |
| disp | input | 16 | Displacement or absolute address |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Access address |
| mem_reg_idx | output | 4 | Register supplying store data for this access |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 16 | Read data, valid with acknowledge |
| rf_we | output | 1 | Register file write for load data |
| rf_widx | output | 4 | Register written with load data |
| rf_wdata | output | 16 | Load data to register file |
| wb_we | output | 1 | Base register update strobe |
| wb_idx | output | 4 | Base register index to update |
| wb_val | output | 16 | New base register value |
| done | output | 1 | Completion pulse |
| pc_adv | output | 1 | Program counter may advance |
| bus_err | output | 1 | Misaligned-address exception |
| ill_err | output | 1 | Illegal-operation exception |

## Verification
The hardest cases to reach from the ports are register overlaps in double-word post-modify loads. Among them, the destination pair wraps from register 15 to register 0 and lands on the base, so the skip rule applies through the wrapped index. The stimulus table builds these overlaps directly. It also combines misalignment with the illegal stack-pointer store to confirm which exception wins. The table varies acknowledge latency from vector to vector, so the hold-until-acknowledge rule is checked under stalls. A directed case raises `start` again in the middle of a stalled access to show that the second launch is dropped.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    parameter int unsigned ADDR_W = 16;
    parameter int unsigned REG_W  = 4;

    typedef enum logic [2:0] {
        AM_IND  = 3'd0,
        AM_DISP = 3'd1,
        AM_ABS  = 3'd2,
        AM_PINC = 3'd3,
        AM_PDEC = 3'd4,
        AM_PUSH = 3'd5
    } amode_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ACC0,
        S_ACC1,
        S_FIN
    } lsu_state_e;

    typedef struct packed {
        logic              st;
        logic              dbl;
        logic [REG_W-1:0]  bidx;
        logic [REG_W-1:0]  didx;
        logic [ADDR_W-1:0] ea;
        logic [ADDR_W-1:0] nbase;
        logic              wb_en;
        logic              bus;
        logic              ill;
    } lsu_op_t;

    function automatic logic [ADDR_W-1:0] step_of(input logic dbl);
        return dbl ? ADDR_W'(4) : ADDR_W'(2);
    endfunction

endpackage

// File: rtl/lsu_ea_calc.sv
module lsu_ea_calc
    import lsu_pkg::*;
#(
    parameter logic [REG_W-1:0] SP_IDX = 4'd15
) (
    input  logic              st,
    input  logic              dbl,
    input  logic [2:0]        mode,
    input  logic [REG_W-1:0]  bidx,
    input  logic [REG_W-1:0]  didx,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] disp,
    output logic [ADDR_W-1:0] ea,
    output logic [ADDR_W-1:0] nbase,
    output logic              wb_en,
    output logic              misal,
    output logic              illegal
);

    logic [ADDR_W-1:0] step;
    logic [REG_W-1:0]  didx_nx;
    logic              upd;
    logic              overlap;
    logic              bad_mode;

    assign step    = step_of(dbl);
    assign didx_nx = didx + REG_W'(1);

    always_comb begin
        ea       = base;
        nbase    = base;
        upd      = 1'b0;
        bad_mode = 1'b0;
        case (mode)
            AM_IND:  ea = base;
            AM_DISP: ea = base + disp;
            AM_ABS:  ea = disp;
            AM_PINC: begin
                ea    = base;
                nbase = base + step;
                upd   = 1'b1;
            end
            AM_PDEC: begin
                ea    = base;
                nbase = base - step;
                upd   = 1'b1;
            end
            AM_PUSH: begin
                ea    = base - step;
                nbase = base - step;
                upd   = 1'b1;
            end
            default: bad_mode = 1'b1;
        endcase
    end

    // Load destination overlapping the base suppresses the update.
    assign overlap = !st && ((didx == bidx) || (dbl && (didx_nx == bidx)));
    assign wb_en   = upd && !overlap;
    assign misal   = ea[0];
    assign illegal = bad_mode
                   || (st && (mode == AM_PDEC) && (bidx == SP_IDX))
                   || (!st && (mode == AM_PUSH));

endmodule

// File: rtl/lsu_seq.sv
module lsu_seq
    import lsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  lsu_op_t           op_in,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [REG_W-1:0]  mem_reg_idx,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_widx,
    output logic [ADDR_W-1:0] rf_wdata,
    output logic              wb_we,
    output logic [REG_W-1:0]  wb_idx,
    output logic [ADDR_W-1:0] wb_val,
    output logic              done,
    output logic              pc_adv,
    output logic              bus_err,
    output logic              ill_err
);

    lsu_state_e state;
    lsu_op_t    cur;
    logic       second;
    logic       exc;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cur   <= '0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    cur   <= op_in;
                    state <= (op_in.ill || op_in.bus) ? S_FIN : S_ACC0;
                end
                S_ACC0: if (mem_ack) state <= cur.dbl ? S_ACC1 : S_FIN;
                S_ACC1: if (mem_ack) state <= S_FIN;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign second      = (state == S_ACC1);
    assign exc         = cur.bus || cur.ill;
    assign busy        = (state != S_IDLE);
    assign mem_req     = (state == S_ACC0) || second;
    assign mem_we      = mem_req && cur.st;
    assign mem_addr    = second ? (cur.ea + ADDR_W'(2)) : cur.ea;
    assign mem_reg_idx = second ? (cur.didx + REG_W'(1)) : cur.didx;

    assign rf_we    = mem_req && mem_ack && !cur.st;
    assign rf_widx  = mem_reg_idx;
    assign rf_wdata = mem_rdata;

    assign done    = (state == S_FIN);
    assign bus_err = done && cur.bus;
    assign ill_err = done && cur.ill;
    assign pc_adv  = done && !exc;
    assign wb_we   = done && !exc && cur.wb_en;
    assign wb_idx  = cur.bidx;
    assign wb_val  = cur.nbase;

endmodule

// File: rtl/lsu_addr_unit.sv
module lsu_addr_unit
    import lsu_pkg::*;
#(
    parameter logic [REG_W-1:0] SP_IDX = 4'd15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_store,
    input  logic              is_double,
    input  logic [2:0]        mode,
    input  logic [REG_W-1:0]  base_idx,
    input  logic [REG_W-1:0]  data_idx,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] disp,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [REG_W-1:0]  mem_reg_idx,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_widx,
    output logic [ADDR_W-1:0] rf_wdata,
    output logic              wb_we,
    output logic [REG_W-1:0]  wb_idx,
    output logic [ADDR_W-1:0] wb_val,
    output logic              done,
    output logic              pc_adv,
    output logic              bus_err,
    output logic              ill_err
);

    logic [ADDR_W-1:0] ea;
    logic [ADDR_W-1:0] nbase;
    logic              wb_en;
    logic              misal;
    logic              illegal;
    lsu_op_t           op_in;

    lsu_ea_calc #(.SP_IDX(SP_IDX)) u_calc (
        .st      (is_store),
        .dbl     (is_double),
        .mode    (mode),
        .bidx    (base_idx),
        .didx    (data_idx),
        .base    (base_val),
        .disp    (disp),
        .ea      (ea),
        .nbase   (nbase),
        .wb_en   (wb_en),
        .misal   (misal),
        .illegal (illegal)
    );

    always_comb begin
        op_in       = '0;
        op_in.st    = is_store;
        op_in.dbl   = is_double;
        op_in.bidx  = base_idx;
        op_in.didx  = data_idx;
        op_in.ea    = ea;
        op_in.nbase = nbase;
        op_in.wb_en = wb_en;
        op_in.ill   = illegal;
        op_in.bus   = misal && !illegal;
    end

    lsu_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .op_in       (op_in),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .busy        (busy),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_reg_idx (mem_reg_idx),
        .rf_we       (rf_we),
        .rf_widx     (rf_widx),
        .rf_wdata    (rf_wdata),
        .wb_we       (wb_we),
        .wb_idx      (wb_idx),
        .wb_val      (wb_val),
        .done        (done),
        .pc_adv      (pc_adv),
        .bus_err     (bus_err),
        .ill_err     (ill_err)
    );

endmodule

// File: rtl/lsu_addr_unit_chk.sv
module lsu_addr_unit_chk
    import lsu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [REG_W-1:0]  mem_reg_idx,
    input logic              mem_ack,
    input logic              rf_we,
    input logic [REG_W-1:0]  rf_widx,
    input logic              wb_we,
    input logic              done,
    input logic              pc_adv,
    input logic              bus_err,
    input logic              ill_err
);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_reg_idx));

    // R2
    bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> done && !pc_adv && !wb_we && !mem_req);

    // R7
    ill_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ill_err |-> done && !pc_adv && !wb_we && !bus_err);

    // R2
    exc_no_access_chk: assert property (@(posedge clk) disable iff (rst)
        done && (bus_err || ill_err) |-> $past(start) && !$past(busy));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    pc_adv_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (pc_adv != (bus_err || ill_err)));

    // R6
    load_write_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack && !mem_we |-> rf_we && (rf_widx == mem_reg_idx));

    // R6
    pair_addr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack |=> !mem_req || (mem_addr == $past(mem_addr) + ADDR_W'(2)));

endmodule

bind lsu_addr_unit lsu_addr_unit_chk u_chk (.*);

// File: tb/tb_lsu_addr_unit.sv
module tb_lsu_addr_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        is_store = 1'b0;
    logic        is_double = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [3:0]  base_idx = 4'd0;
    logic [3:0]  data_idx = 4'd0;
    logic [15:0] base_val = 16'd0;
    logic [15:0] disp = 16'd0;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = 16'd0;
    logic        busy, mem_req, mem_we, rf_we, wb_we, done, pc_adv, bus_err, ill_err;
    logic [15:0] mem_addr, rf_wdata, wb_val;
    logic [3:0]  mem_reg_idx, rf_widx, wb_idx;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    lsu_addr_unit dut (.*);

    typedef struct packed {
        logic        st;
        logic        dbl;
        logic [2:0]  md;
        logic [3:0]  bidx;
        logic [3:0]  didx;
        logic [15:0] base;
        logic [15:0] dsp;
        logic [1:0]  nacc;
        logic [15:0] addr0;
        logic        wbwe;
        logic [15:0] wbval;
        logic        bus;
        logic        ill;
    } vec_t;

    localparam int NV = 20;
    // fields: st dbl mode bidx didx base disp nacc addr0 wbwe wbval bus ill
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0,1'b0,3'd0,4'd1, 4'd2, 16'h1000,16'h0000,2'd1,16'h1000,1'b0,16'h0000,1'b0,1'b0}, // R1 indirect
        '{1'b1,1'b0,3'd1,4'd1, 4'd2, 16'hFFF0,16'h0014,2'd1,16'h0004,1'b0,16'h0000,1'b0,1'b0}, // R1 disp wrap
        '{1'b0,1'b1,3'd2,4'd1, 4'd6, 16'h0000,16'h2002,2'd2,16'h2002,1'b0,16'h0000,1'b0,1'b0}, // R1 R6 absolute
        '{1'b0,1'b0,3'd3,4'd3, 4'd4, 16'h0100,16'h0000,2'd1,16'h0100,1'b1,16'h0102,1'b0,1'b0}, // R3 inc word
        '{1'b0,1'b1,3'd4,4'd3, 4'd6, 16'h0200,16'h0000,2'd2,16'h0200,1'b1,16'h01FC,1'b0,1'b0}, // R3 dec double
        '{1'b0,1'b0,3'd3,4'd5, 4'd5, 16'h0300,16'h0000,2'd1,16'h0300,1'b0,16'h0000,1'b0,1'b0}, // R4 overlap
        '{1'b0,1'b1,3'd3,4'd5, 4'd4, 16'h0300,16'h0000,2'd2,16'h0300,1'b0,16'h0000,1'b0,1'b0}, // R5 base=n+1
        '{1'b0,1'b1,3'd4,4'd4, 4'd4, 16'h0500,16'h0000,2'd2,16'h0500,1'b0,16'h0000,1'b0,1'b0}, // R5 base=n
        '{1'b1,1'b0,3'd4,4'd15,4'd1, 16'h0600,16'h0000,2'd0,16'h0000,1'b0,16'h0000,1'b0,1'b1}, // R7 sp dec store
        '{1'b1,1'b1,3'd5,4'd15,4'd2, 16'h0400,16'h0000,2'd2,16'h03FC,1'b1,16'h03FC,1'b0,1'b0}, // R8 push double
        '{1'b1,1'b0,3'd0,4'd1, 4'd2, 16'h0301,16'h0000,2'd0,16'h0000,1'b0,16'h0000,1'b1,1'b0}, // R2 odd
        '{1'b1,1'b1,3'd1,4'd1, 4'd2, 16'h1000,16'h0003,2'd0,16'h0000,1'b0,16'h0000,1'b1,1'b0}, // R2 odd double
        '{1'b1,1'b0,3'd5,4'd15,4'd2, 16'h0001,16'h0000,2'd0,16'h0000,1'b0,16'h0000,1'b1,1'b0}, // R8 odd after dec
        '{1'b1,1'b0,3'd5,4'd15,4'd3, 16'h0000,16'h0000,2'd1,16'hFFFE,1'b1,16'hFFFE,1'b0,1'b0}, // R8 wrap
        '{1'b0,1'b0,3'd5,4'd15,4'd3, 16'h0400,16'h0000,2'd0,16'h0000,1'b0,16'h0000,1'b0,1'b1}, // R7 push load
        '{1'b1,1'b1,3'd3,4'd2, 4'd2, 16'hFFFE,16'h0000,2'd2,16'hFFFE,1'b1,16'h0002,1'b0,1'b0}, // R3 store no skip
        '{1'b0,1'b1,3'd3,4'd0, 4'd15,16'h0010,16'h0000,2'd2,16'h0010,1'b0,16'h0000,1'b0,1'b0}, // R5 R6 pair wrap
        '{1'b1,1'b0,3'd4,4'd3, 4'd1, 16'h0000,16'h0000,2'd1,16'h0000,1'b1,16'hFFFE,1'b0,1'b0}, // R3 dec wrap
        '{1'b0,1'b1,3'd3,4'd7, 4'd2, 16'h0701,16'h0000,2'd0,16'h0000,1'b0,16'h0000,1'b1,1'b0}, // R2 odd inc
        '{1'b1,1'b0,3'd4,4'd15,4'd1, 16'h0601,16'h0000,2'd0,16'h0000,1'b0,16'h0000,1'b0,1'b1}  // R7 over R2
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input vec_t v, input int lat, input bit poke);
        int          nacc = 0;
        int          wcnt = 0;
        int          cyc = 0;
        bit          got_done = 0;
        bit          poked = 0;
        logic [15:0] prev = 16'd0;
        logic [3:0]  exp_reg;
        logic [15:0] exp_addr;
        @(negedge clk);
        is_store = v.st; is_double = v.dbl; mode = v.md;
        base_idx = v.bidx; data_idx = v.didx; base_val = v.base; disp = v.dsp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!got_done && cyc < 50) begin
            if (poked) start = 1'b0;
            if (mem_req) begin
                if (wcnt == lat) begin
                    mem_ack = 1'b1;
                    mem_rdata = mem_addr ^ 16'h5A5A;
                    #1;
                    exp_addr = v.addr0 + 16'(2 * nacc);
                    exp_reg  = v.didx + 4'(nacc);
                    check(mem_addr == exp_addr, "R1 R6 R8 access address", mem_addr, exp_addr);
                    check(mem_reg_idx == exp_reg, "R6 access register", mem_reg_idx, exp_reg);
                    check(mem_we == v.st, "R6 write enable", mem_we, v.st);
                    check(rf_we == !v.st, "R6 load write strobe", rf_we, !v.st);
                    if (!v.st) begin
                        check(rf_widx == exp_reg, "R6 load register", rf_widx, exp_reg);
                        check(rf_wdata == (exp_addr ^ 16'h5A5A), "R6 load data", rf_wdata, exp_addr ^ 16'h5A5A);
                    end
                    nacc++;
                    wcnt = 0;
                end else begin
                    mem_ack = 1'b0;
                    if (wcnt > 0)
                        check(mem_addr == prev, "R10 address held", mem_addr, prev);
                    prev = mem_addr;
                    if (poke && wcnt == 1 && !poked) begin
                        start = 1'b1; base_val = 16'h0900; mode = 3'd1; poked = 1;
                    end
                    wcnt++;
                end
            end else begin
                mem_ack = 1'b0;
            end
            if (done) begin
                got_done = 1;
                check(bus_err == v.bus, "R2 bus error", bus_err, v.bus);
                check(ill_err == v.ill, "R7 illegal", ill_err, v.ill);
                check(pc_adv == !(v.bus || v.ill), "R9 pc advance", pc_adv, !(v.bus || v.ill));
                check(wb_we == v.wbwe, "R3 R4 R5 writeback enable", wb_we, v.wbwe);
                if (v.wbwe) begin
                    check(wb_val == v.wbval, "R3 R8 writeback value", wb_val, v.wbval);
                    check(wb_idx == v.bidx, "R3 writeback register", wb_idx, v.bidx);
                end
            end
            @(negedge clk);
            cyc++;
        end
        mem_ack = 1'b0;
        start = 1'b0;
        check(got_done, "R9 completion seen", got_done, 1);
        check(nacc == int'(v.nacc), "R2 R6 R7 access count", nacc, v.nacc);
        check(!done, "R9 single pulse", done, 0);
    endtask

    initial begin
        for (int w = 0; w < 100000; w++) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        vec_t pv;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(!busy, "R11 busy", busy, 0);
        check(!mem_req, "R11 mem_req", mem_req, 0);
        check(!rf_we && !wb_we, "R11 write strobes", {rf_we, wb_we}, 0);
        check(!done, "R11 done", done, 0);

        for (int i = 0; i < NV; i++) run_op(VECS[i], i % 3, 1'b0);

        // R10 start raised while busy is ignored
        pv = '{1'b1,1'b0,3'd0,4'd1,4'd2,16'h0800,16'h0000,2'd1,16'h0800,1'b0,16'h0000,1'b0,1'b0};
        run_op(pv, 3, 1'b1);
        for (int k = 0; k < 4; k++) begin
            check(!mem_req && !busy, "R10 second start dropped", {mem_req, busy}, 0);
            @(negedge clk);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule